// File: doc/BRIEF.md
# Verified Command Output Controller

This block sits behind a packet receiver and turns one command, sent with a redundancy check, into an action on a single output pin. Inside a packet, framed by start and end markers, the first three valid bytes are taken in order. The first is the command byte. The second must be its bitwise ones' complement. The third must repeat the first. If all three agree, the command is accepted. If any of them disagrees, or the packet ends early, the command is rejected as noise and the pin is not touched.

Bits [1:0] of the accepted command byte choose the action:
- `00` does nothing.
- `01` drives the pin low.
- `10` inverts the pin.
- `11` raises the pin for a fixed number of millisecond ticks and then drops it to low.

The tick input is a one-cycle strobe from a shared millisecond timebase. The pulse length is set by a parameter, so a real-time value and a short test value both use the same logic.

Top module: `verified_cmd_pin`

## Requirements
- R1: After reset, `pin_out`, `accept` and `reject` are all low.
- R2: When the first three bytes of a packet are D, ~D and D, `accept` is high for exactly one cycle, in the cycle after the third byte is strobed.
- R3: If the second byte is not the bitwise inverse of the first, `reject` pulses for one cycle after the third byte is strobed, and `pin_out` is unchanged.
- R4: If the third byte differs from the first, `reject` pulses for one cycle after the third byte is strobed, and `pin_out` is unchanged.
- R5: If `pkt_end` arrives before the third byte, `reject` pulses in the cycle after `pkt_end`. An asserted `pkt_start` restarts the byte count from zero, and a byte strobed in the same cycle as `pkt_start` is dropped.
- R6: An accepted command with bits [1:0] = 00 changes neither `pin_out` nor the progress of a running pulse.
- R7: An accepted command with bits [1:0] = 01 drives `pin_out` low from the cycle after the third byte, and cancels any running pulse.
- R8: An accepted command with bits [1:0] = 10 inverts `pin_out` from the cycle after the third byte, and cancels any running pulse.
- R9: An accepted command with bits [1:0] = 11 sets `pin_out` high from the cycle after the third byte. The pin falls low in the cycle after the PULSE_MS-th following `ms_tick`. Accepting the same command again during the pulse restarts the count.
- R10: At most one of `accept` and `reject` is high in any cycle.
- R11: Bytes strobed outside a packet are ignored. This covers bytes before any `pkt_start` and bytes after the third byte has been evaluated. `pkt_end` outside a packet is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Start-of-packet marker |
| pkt_end | input | 1 | End-of-packet marker |
| byte_vld | input | 1 | Payload byte strobe |
| byte_data | input | 8 | Payload byte |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| pin_out | output | 1 | Controlled output pin |
| accept | output | 1 | One-cycle pulse: command accepted |
| reject | output | 1 | One-cycle pulse: command rejected |

## Verification
The bench builds the block with PULSE_MS = 5. At that length the bench can count out a whole pulse tick by tick. It can also restart a pulse partway through, and cancel it with a low or toggle command before it expires, all in a few dozen cycles. Random packets with ticks on random cycles also land many ticks inside active pulses. This puts expiry in the same cycle as a new command and near packet boundaries, which a 100-tick pulse would rarely reach.

// File: rtl/verified_cmd_pin.sv
module verified_cmd_pin #(
  parameter int PULSE_MS = 100,
  localparam int RW = $clog2(PULSE_MS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_start,
  input  logic       pkt_end,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       ms_tick,
  output logic       pin_out,
  output logic       accept,
  output logic       reject
);

  logic          in_pkt;
  logic [1:0]    cnt;
  logic [7:0]    first_q;
  logic          comp_ok;
  logic          pin_q, act_q;
  logic [RW-1:0] rem_q;
  logic          acc_q, rej_q;

  wire live      = in_pkt && !pkt_start;
  wire third     = live && byte_vld && cnt == 2'd2;
  wire good      = third && comp_ok && byte_data == first_q;
  wire bad_third = third && !good;
  wire short_end = live && pkt_end && !third;
  wire [1:0] code = first_q[1:0];
  wire take_cmd  = good && code != 2'b00;

  assign pin_out = pin_q;
  assign accept  = acc_q;
  assign reject  = rej_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt  <= 1'b0;
      cnt     <= '0;
      first_q <= '0;
      comp_ok <= 1'b0;
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      acc_q <= good;
      rej_q <= bad_third || short_end;
      if (pkt_start) begin
        in_pkt  <= 1'b1;
        cnt     <= '0;
        comp_ok <= 1'b0;
      end else if (in_pkt) begin
        if (third || short_end) begin
          in_pkt <= 1'b0;
        end else if (byte_vld) begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd0) first_q <= byte_data;
          else             comp_ok <= (byte_data == ~first_q);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (take_cmd) begin
      unique case (code)
        2'b01: begin pin_q <= 1'b0;   act_q <= 1'b0; end
        2'b10: begin pin_q <= ~pin_q; act_q <= 1'b0; end
        default: begin
          pin_q <= 1'b1;
          act_q <= 1'b1;
          rem_q <= RW'(PULSE_MS);
        end
      endcase
    end else if (act_q && ms_tick) begin
      rem_q <= rem_q - RW'(1);
      if (rem_q == RW'(1)) begin
        pin_q <= 1'b0;
        act_q <= 1'b0;
      end
    end
  end

  // R10
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept, reject}));

  // R3 R4
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_third && !act_q) |=> $stable(pin_out));

  // R7
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good && code == 2'b01) |=> !pin_out);

  // R9
  pulse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good && code == 2'b11) |=> (pin_out && rem_q == RW'(PULSE_MS)));

  // R9
  pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> pin_out);

  // R9
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= RW'(PULSE_MS));

endmodule

// File: tb/tb_verified_cmd_pin.sv
module tb_verified_cmd_pin;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 0, pkt_end = 0, byte_vld = 0, ms_tick = 0;
  logic [7:0] byte_data = '0;
  logic pin_out, accept, reject;

  int errors = 0, checks = 0;
  bit done = 0;
  bit rnd_tick = 0;

  bit m_pin, m_act, m_inpkt, m_cok;
  int m_rem, m_cnt;
  logic [7:0] m_b0;

  always #10 clk = ~clk;

  verified_cmd_pin #(.PULSE_MS(P)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .byte_vld(byte_vld), .byte_data(byte_data), .ms_tick(ms_tick),
    .pin_out(pin_out), .accept(accept), .reject(reject));

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit s, bit e, bit v, logic [7:0] d, bit t, string tag);
    bit acc = 0, rej = 0, third = 0;
    pkt_start = s; pkt_end = e; byte_vld = v; byte_data = d; ms_tick = t;
    if (s) begin
      m_inpkt = 1; m_cnt = 0; m_cok = 0;
    end else if (m_inpkt) begin
      if (v && m_cnt == 2) begin
        third = 1;
        if (m_cok && d == m_b0) acc = 1; else rej = 1;
        m_inpkt = 0;
      end else if (e) begin
        rej = 1; m_inpkt = 0;
      end else if (v) begin
        if (m_cnt == 0) m_b0 = d; else m_cok = (d == ~m_b0);
        m_cnt++;
      end
    end
    if (acc && m_b0[1:0] != 2'b00) begin
      case (m_b0[1:0])
        2'b01: begin m_pin = 0; m_act = 0; end
        2'b10: begin m_pin = !m_pin; m_act = 0; end
        default: begin m_pin = 1; m_act = 1; m_rem = P; end
      endcase
    end else if (m_act && t) begin
      if (m_rem == 1) begin m_pin = 0; m_act = 0; end
      m_rem--;
    end
    @(posedge clk);
    @(negedge clk);
    chk(pin_out === m_pin, tag, "pin_out", pin_out, m_pin);
    chk(accept === acc, tag, "accept", accept, acc);
    chk(reject === rej, tag, "reject", reject, rej);
  endtask

  function automatic bit rt();
    return rnd_tick && ($urandom % 4 == 0);
  endfunction

  task automatic idle(int n, bit t, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, t, tag);
  endtask

  task automatic pkt(logic [7:0] a, logic [7:0] b, logic [7:0] c, int n, string tag);
    step(1, 0, 0, 8'h00, rt(), tag);
    if (n > 0) step(0, 0, 1, a, rt(), tag);
    if (n > 1) step(0, 0, 1, b, rt(), tag);
    if (n > 2) step(0, 0, 1, c, rt(), tag);
    step(0, 1, 0, 8'h00, rt(), tag);
  endtask

  task automatic cmd(logic [7:0] a, string tag);
    pkt(a, ~a, a, 3, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pin_out === 0, "R1", "pin_out", pin_out, 0);
    chk(accept === 0, "R1", "accept", accept, 0);
    chk(reject === 0, "R1", "reject", reject, 0);
    rst_n = 1;
    @(negedge clk);

    step(0, 0, 1, 8'h03, 0, "R11");
    step(0, 1, 0, 8'h00, 0, "R11");
    cmd(8'h57, "R2");
    cmd(8'h56, "R8");
    cmd(8'h56, "R8");
    cmd(8'h55, "R7");
    idle(P + 1, 1, "R9");
    cmd(8'hA3, "R9");
    idle(P, 1, "R9");
    idle(2, 1, "R9");
    cmd(8'h03, "R9");
    idle(3, 1, "R9");
    cmd(8'h03, "R9");
    idle(P + 2, 1, "R9");
    cmd(8'h03, "R6");
    idle(2, 1, "R6");
    cmd(8'h40, "R6");
    idle(P, 1, "R6");
    cmd(8'h40, "R6");
    cmd(8'h03, "R10");
    idle(2, 1, "R10");
    cmd(8'h01, "R10");
    idle(P + 1, 1, "R10");
    cmd(8'h03, "R10");
    idle(1, 1, "R10");
    cmd(8'h02, "R10");
    idle(P + 1, 1, "R10");
    cmd(8'h02, "R8");
    pkt(8'h01, 8'hFF, 8'h01, 3, "R3");
    pkt(8'h01, 8'hFE, 8'h03, 3, "R4");
    pkt(8'h01, 8'hFE, 8'h01, 2, "R5");
    pkt(8'h01, 8'hFE, 8'h01, 0, "R5");
    step(1, 0, 0, 8'h00, 0, "R5");
    step(0, 0, 1, 8'h77, 0, "R5");
    step(1, 0, 1, 8'h55, 0, "R5");
    step(0, 0, 1, 8'h01, 0, "R5");
    step(0, 0, 1, 8'hFE, 0, "R5");
    step(0, 0, 1, 8'h01, 0, "R5");
    step(0, 0, 1, 8'h02, 0, "R11");
    step(0, 0, 1, 8'hFD, 0, "R11");
    step(0, 0, 1, 8'h02, 0, "R11");
    step(0, 1, 0, 8'h00, 0, "R11");

    rnd_tick = 1;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = ~a;
      logic [7:0] c = a;
      int sel = $urandom % 6;
      int n = 3;
      if (sel == 3) b = b ^ (8'd1 << ($urandom % 8));
      if (sel == 4) c = c ^ (8'd1 << ($urandom % 8));
      if (sel == 5) n = $urandom % 3;
      pkt(a, b, c, n, sel == 3 ? "R3" : sel == 4 ? "R4" : sel == 5 ? "R5" : "R2");
      idle($urandom % 4, 1, "R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule